// File: doc/BRIEF.md
# Cascading Interrupt Controller

This block gathers up to 32 main interrupt request lines and 11 secondary request lines. The secondary lines are grouped three at a time. Each group feeds one main line, called its parent. Every request is caught in a sticky pending register. Main requests pass through a main mask and secondary requests through a separate secondary mask. Among the unmasked pending main requests, the lowest index wins. The winner is loaded as a single bit into an active register, and its bit index is published in a winner register. A single interrupt line to the processor is high while the active register holds a bit.

Software reaches the block through a plain register bus made of a word address, write data, a write strobe and registered read data. A handler reads the winner index and clears the pending bits by writing ones: the secondary pending bit first, then the main pending bit, then the active bit. Only after the active register is empty can a new winner be loaded. A higher-priority request that arrives in the meantime waits its turn.

Register map (word address, 3 bits): 0 main pending (write ones to clear), 1 main mask (read/write), 2 active (write ones to clear), 3 winner index (read only), 4 secondary pending (write ones to clear), 5 secondary mask (read/write, 11 bits). Any other address reads zero.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset the main pending, active, secondary pending and winner registers read 0, the main mask reads 0xFFFFFFFF, the secondary mask reads 0x7FF, and `irq_o` is low.
- R2: A high `irq_in[i]` sets main pending bit i at the next clock edge whatever the mask. The bit stays set after the input drops, until software clears it.
- R3: Writing to the main pending (address 0), active (address 2) or secondary pending (address 4) register clears exactly the bits written as one. A write of zero changes nothing, and a write of all ones clears the whole register.
- R4: A main mask bit of 1 keeps that pending line out of arbitration, and a bit of 0 lets it compete.
- R5: The active register never holds more than one set bit.
- R6: When several unmasked main pending bits are set, the lowest index is loaded into the active register.
- R7: The active register loads a new winner only while it is zero. An active bit is not replaced by a later request, even one of lower index.
- R8: The winner register (address 3) reads the index of the set active bit, and reads 0 when the active register is empty.
- R9: `irq_o` is high exactly when the active register is non-zero.
- R10: A high `sub_in[k]` sets secondary pending bit k at the next clock edge whatever the secondary mask. Secondary line k belongs to group k/3, whose parent is main line 28 + k/3 (lines 28 to 31 by default).
- R11: A parent main line requests while any secondary pending bit of its group has a secondary mask bit of 0. A masked secondary pending bit produces no main request.
- R12: The secondary mask is 11 bits wide and is written whole. A 0 bit enables that secondary line and a 1 bit masks it, and the register reads back the value written.
- R13: Read data appears on `bus_rdata` one clock after the address is presented and reflects the register state before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Main interrupt request lines, level sampled |
| sub_in | input | 11 | Secondary request lines, level sampled |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A wrong active register shows at the ports at once. `irq_o` disagrees with a read of address 2, or the winner index points at a bit that is not set, and either is visible within two cycles of the request that caused it. Faults in the mask or cascade logic show as a missing or wrong winner two clocks after the request for a main line, and three clocks after it for a secondary line. A sticky bit that leaks away shows on the next read of its pending register. The directed tests read every register after each step so that these faults surface within a few cycles.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int BUS_AW = 3;
  localparam int BUS_DW = 32;

  typedef enum logic [BUS_AW-1:0] {
    SEL_RAW     = 3'd0,
    SEL_MASK    = 3'd1,
    SEL_ACTIVE  = 3'd2,
    SEL_WINNER  = 3'd3,
    SEL_SUBRAW  = 3'd4,
    SEL_SUBMASK = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/icu_sub_cascade.sv
module icu_sub_cascade #(
  parameter int NUM_SUB        = 11,
  parameter int SUBS_PER_GROUP = 3,
  localparam int NUM_GROUPS    = (NUM_SUB + SUBS_PER_GROUP - 1) / SUBS_PER_GROUP
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SUB-1:0]    sub_in,
  input  logic [NUM_SUB-1:0]    clr_bits,
  input  logic                  mask_we,
  input  logic [NUM_SUB-1:0]    mask_wval,
  output logic [NUM_SUB-1:0]    sub_pend_q,
  output logic [NUM_SUB-1:0]    sub_mask_q,
  output logic [NUM_GROUPS-1:0] grp_req
);
  logic [NUM_SUB-1:0] live;

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_pend_q <= '0;
      sub_mask_q <= '1;
    end else begin
      sub_pend_q <= (sub_pend_q & ~clr_bits) | sub_in;
      if (mask_we) sub_mask_q <= mask_wval;
    end
  end

  assign live = sub_pend_q & ~sub_mask_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int LO = g * SUBS_PER_GROUP;
    localparam int HI = ((LO + SUBS_PER_GROUP) > NUM_SUB) ? NUM_SUB - 1
                                                          : LO + SUBS_PER_GROUP - 1;
    assign grp_req[g] = |live[HI:LO];
  end
endmodule

// File: rtl/icu_src_latch.sv
module icu_src_latch #(
  parameter int NUM_MAIN = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_MAIN-1:0] req,
  input  logic [NUM_MAIN-1:0] clr_bits,
  output logic [NUM_MAIN-1:0] pend_q
);
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_bits) | req;
  end
endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter #(
  parameter int N      = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     cand,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             any
);
  always_comb begin
    grant     = '0;
    grant_idx = '0;
    any       = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && !any) begin
        any       = 1'b1;
        grant[i]  = 1'b1;
        grant_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int NUM_MAIN       = 32,
  parameter int NUM_SUB        = 11,
  parameter int SUBS_PER_GROUP = 3,
  parameter int PARENT_BASE    = 28
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_MAIN-1:0] irq_in,
  input  logic [NUM_SUB-1:0]  sub_in,
  input  logic [BUS_AW-1:0]   bus_addr,
  input  logic [BUS_DW-1:0]   bus_wdata,
  input  logic                bus_we,
  output logic [BUS_DW-1:0]   bus_rdata,
  output logic                irq_o
);
  localparam int NUM_GROUPS = (NUM_SUB + SUBS_PER_GROUP - 1) / SUBS_PER_GROUP;
  localparam int IDX_W      = (NUM_MAIN > 1) ? $clog2(NUM_MAIN) : 1;

  logic [NUM_MAIN-1:0]   main_req;
  logic [NUM_MAIN-1:0]   src_pend;
  logic [NUM_MAIN-1:0]   main_mask;
  logic [NUM_MAIN-1:0]   active_q;
  logic [IDX_W-1:0]      win_idx;
  logic [NUM_MAIN-1:0]   grant;
  logic [IDX_W-1:0]      grant_idx;
  logic                  grant_any;
  logic [NUM_SUB-1:0]    sub_pend;
  logic [NUM_SUB-1:0]    sub_mask;
  logic [NUM_GROUPS-1:0] grp_req;
  logic [NUM_MAIN-1:0]   wr_main;
  logic [NUM_SUB-1:0]    wr_sub;
  logic                  we_raw, we_mask, we_active, we_subraw, we_submask;
  logic [NUM_MAIN-1:0]   active_left;

  assign wr_main    = bus_wdata[NUM_MAIN-1:0];
  assign wr_sub     = bus_wdata[NUM_SUB-1:0];
  assign we_raw     = bus_we && (bus_addr == SEL_RAW);
  assign we_mask    = bus_we && (bus_addr == SEL_MASK);
  assign we_active  = bus_we && (bus_addr == SEL_ACTIVE);
  assign we_subraw  = bus_we && (bus_addr == SEL_SUBRAW);
  assign we_submask = bus_we && (bus_addr == SEL_SUBMASK);

  icu_sub_cascade #(.NUM_SUB(NUM_SUB), .SUBS_PER_GROUP(SUBS_PER_GROUP)) u_sub (
    .clk(clk), .rst(rst), .sub_in(sub_in),
    .clr_bits(we_subraw ? wr_sub : '0),
    .mask_we(we_submask), .mask_wval(wr_sub),
    .sub_pend_q(sub_pend), .sub_mask_q(sub_mask), .grp_req(grp_req)
  );

  always_comb begin
    main_req = irq_in;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      main_req[PARENT_BASE + g] = irq_in[PARENT_BASE + g] | grp_req[g];
    end
  end

  icu_src_latch #(.NUM_MAIN(NUM_MAIN)) u_src (
    .clk(clk), .rst(rst), .req(main_req),
    .clr_bits(we_raw ? wr_main : '0), .pend_q(src_pend)
  );

  icu_arbiter #(.N(NUM_MAIN)) u_arb (
    .cand(src_pend & ~main_mask), .grant(grant),
    .grant_idx(grant_idx), .any(grant_any)
  );

  assign active_left = active_q & ~(we_active ? wr_main : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      main_mask <= '1;
      active_q  <= '0;
      win_idx   <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (we_mask) main_mask <= wr_main;
      if (active_q == '0) begin
        if (grant_any) begin
          active_q <= grant;
          win_idx  <= grant_idx;
          irq_o    <= 1'b1;
        end
      end else if (active_left == '0) begin
        active_q <= '0;
        win_idx  <= '0;
        irq_o    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        SEL_RAW:     bus_rdata <= BUS_DW'(src_pend);
        SEL_MASK:    bus_rdata <= BUS_DW'(main_mask);
        SEL_ACTIVE:  bus_rdata <= BUS_DW'(active_q);
        SEL_WINNER:  bus_rdata <= BUS_DW'(win_idx);
        SEL_SUBRAW:  bus_rdata <= BUS_DW'(sub_pend);
        SEL_SUBMASK: bus_rdata <= BUS_DW'(sub_mask);
        default:     bus_rdata <= '0;
      endcase
    end
  end
endmodule

module irq_cascade_ctrl_chk
  import irq_cascade_pkg::*;
#(
  parameter int NUM_MAIN = 32,
  localparam int IDX_W   = (NUM_MAIN > 1) ? $clog2(NUM_MAIN) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_we,
  input logic [BUS_AW-1:0]   bus_addr,
  input logic [BUS_DW-1:0]   bus_wdata,
  input logic [NUM_MAIN-1:0] src_pend,
  input logic [NUM_MAIN-1:0] main_mask,
  input logic [NUM_MAIN-1:0] active_q,
  input logic [IDX_W-1:0]    win_idx,
  input logic                irq_o
);
  logic clr_hit;
  assign clr_hit = bus_we && (bus_addr == SEL_ACTIVE) &&
                   ((bus_wdata[NUM_MAIN-1:0] & active_q) != '0);

  AST_ACTIVE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(active_q)); // R5
  AST_IRQ_FOLLOWS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    irq_o == (active_q != '0)); // R9
  AST_WINNER_POINTS_AT_BIT: assert property (@(posedge clk) disable iff (rst)
    (active_q != '0) |-> active_q[win_idx]); // R8
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    ((active_q != '0) && !clr_hit) |=> $stable(active_q)); // R7
  AST_LOAD_FROM_UNMASKED: assert property (@(posedge clk) disable iff (rst)
    (active_q == '0) |=> ((active_q & ~$past(src_pend & ~main_mask)) == '0)); // R4
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && (bus_addr == SEL_RAW)) |=> ((src_pend & $past(src_pend)) == $past(src_pend))); // R2
endmodule

bind irq_cascade_ctrl irq_cascade_ctrl_chk #(.NUM_MAIN(NUM_MAIN)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .src_pend(src_pend), .main_mask(main_mask),
  .active_q(active_q), .win_idx(win_idx), .irq_o(irq_o)
);

// File: tb/sim_irq_cascade_ctrl.sv
`timescale 1ns/1ps
module sim_irq_cascade_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic [10:0] sub_in = '0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_RAW = 3'd0, A_MASK = 3'd1, A_ACT = 3'd2,
                         A_WIN = 3'd3, A_SUBRAW = 3'd4, A_SUBMASK = 3'd5;

  always #10 clk = ~clk;

  irq_cascade_ctrl u0 (
    .clk(clk), .rst(rst), .irq_in(irq_in), .sub_in(sub_in),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pulse_main(input logic [31:0] bits);
    @(negedge clk); irq_in = bits;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic pulse_sub(input logic [10:0] bits);
    @(negedge clk); sub_in = bits;
    @(negedge clk); sub_in = '0;
  endtask

  task automatic clear_everything();
    wr(A_SUBRAW, 32'h7FF);
    wr(A_RAW, 32'hFFFF_FFFF);
    wr(A_ACT, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 irq_o after reset", {31'd0, irq_o}, 32'd0);
    rd_chk("R1 R13 main pending", A_RAW, 32'd0);
    rd_chk("R1 main mask", A_MASK, 32'hFFFF_FFFF);
    rd_chk("R1 active", A_ACT, 32'd0);
    rd_chk("R1 winner", A_WIN, 32'd0);
    rd_chk("R1 sub pending", A_SUBRAW, 32'd0);
    rd_chk("R1 sub mask", A_SUBMASK, 32'h7FF);
    rd_chk("R13 unused address", 3'd7, 32'd0);
  endtask

  task automatic t_mask_block();
    pulse_main(32'h20);
    repeat (2) @(negedge clk);
    rd_chk("R2 sticky pending after input drop", A_RAW, 32'h20);
    rd_chk("R4 masked line not active", A_ACT, 32'd0);
    chk("R4 masked line no irq", {31'd0, irq_o}, 32'd0);
    wr(A_MASK, ~32'h20);
    repeat (2) @(negedge clk);
    chk("R9 irq high with active", {31'd0, irq_o}, 32'd1);
    rd_chk("R4 unmasked line active", A_ACT, 32'h20);
    rd_chk("R8 winner index 5", A_WIN, 32'd5);
    wr(A_RAW, 32'h20);
    wr(A_ACT, 32'h20);
    repeat (2) @(negedge clk);
    rd_chk("R3 active cleared", A_ACT, 32'd0);
    rd_chk("R8 winner zero when empty", A_WIN, 32'd0);
    chk("R9 irq low when empty", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_priority();
    wr(A_MASK, 32'd0);
    pulse_main(32'h208);
    repeat (2) @(negedge clk);
    rd_chk("R6 lowest of 9 and 3", A_ACT, 32'h8);
    rd_chk("R6 winner index 3", A_WIN, 32'd3);
    pulse_main(32'h2);
    repeat (2) @(negedge clk);
    rd_chk("R7 no preempt by line 1", A_ACT, 32'h8);
    wr(A_RAW, 32'd0);
    rd_chk("R3 write zero keeps pending", A_RAW, 32'h20A);
    wr(A_RAW, 32'h8);
    rd_chk("R3 only written bit cleared", A_RAW, 32'h202);
    wr(A_ACT, 32'h8);
    repeat (2) @(negedge clk);
    rd_chk("R7 next winner line 1", A_WIN, 32'd1);
    wr(A_RAW, 32'h2);
    wr(A_ACT, 32'h2);
    repeat (2) @(negedge clk);
    rd_chk("R6 then line 9", A_ACT, 32'h200);
    wr(A_RAW, 32'hFFFF_FFFF);
    wr(A_ACT, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    rd_chk("R3 all ones clears pending", A_RAW, 32'd0);
    rd_chk("R3 all ones clears active", A_ACT, 32'd0);
    chk("R9 irq low after clear", {31'd0, irq_o}, 32'd0);
  endtask

  task automatic t_cascade();
    pulse_sub(11'h010);
    repeat (3) @(negedge clk);
    rd_chk("R10 sub pending set while masked", A_SUBRAW, 32'h10);
    rd_chk("R11 masked sub no main request", A_RAW, 32'd0);
    chk("R11 masked sub no irq", {31'd0, irq_o}, 32'd0);
    wr(A_SUBMASK, 32'h7EF);
    repeat (3) @(negedge clk);
    rd_chk("R12 sub mask readback", A_SUBMASK, 32'h7EF);
    rd_chk("R11 parent 29 active", A_ACT, 32'h2000_0000);
    rd_chk("R10 sub 4 maps to line 29", A_WIN, 32'd29);
    clear_everything();
    chk("R3 irq low after cascade clear", {31'd0, irq_o}, 32'd0);
    rd_chk("R3 sub pending cleared", A_SUBRAW, 32'd0);
    wr(A_SUBMASK, 32'h3EB);
    pulse_sub(11'h400);
    repeat (3) @(negedge clk);
    rd_chk("R10 sub 10 maps to line 31", A_WIN, 32'd31);
    clear_everything();
    pulse_sub(11'h004);
    repeat (3) @(negedge clk);
    rd_chk("R10 sub 2 maps to line 28", A_WIN, 32'd28);
    clear_everything();
    wr(A_SUBMASK, 32'h7FF);
    pulse_sub(11'h004);
    repeat (3) @(negedge clk);
    rd_chk("R12 remasked sub blocked", A_ACT, 32'd0);
    clear_everything();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mask_block();
    t_priority();
    t_cascade();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule